// File: doc/BRIEF.md
# GPIO Pin Interrupt Port

This block watches a group of input pins and raises one shared interrupt for all of them. Each pin can be armed on its own. A single mode bit covers every pin. In level mode an armed pin asks for service while it is low. In change mode an armed pin asks for service while its level differs from a stored snapshot. The snapshot is taken each time software reads the pin-data register. The per-pin requests are merged onto one active-low line that behaves like an open-drain wired-OR, and the block brings that line out on `line_n`.

A system stage samples the shared line and looks for its high-to-low step. When the GPIO mask bit and the global interrupt enable are both set, that step sets a sticky pending flag. The flag stays set until software clears it through an acknowledge write. Releasing the line is level based: the line goes high only once no armed pin still qualifies. A second pin that asserts while the line is already low therefore raises nothing new. Software reads the status register to find which pins are asking.

Register access is a synchronous strobe interface. Read data is registered and appears the cycle after `rd_en`. Address map (3-bit `addr`):
- 0: pin levels, read-only. Reading it also stores the snapshot.
- 1: enable per pin.
- 2: mode, bit 0 (0 = low level, 1 = change since last read).
- 3: control, with bit 0 = GPIO mask and bit 1 = global enable.
- 4: request status, read-only.
- 5: acknowledge, write-only. Bit 0 set clears the pending flag.

Unused addresses read as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: In mode 0, an enabled pin whose synchronized level is 0 shows a 1 in status (addr 4) and drives `line_n` low. It releases the line once the pin returns high.
- R2: In mode 1, an enabled pin shows a request while its level differs from the snapshot, in either direction.
- R3: A pin whose enable bit is 0 never shows a request and never pulls `line_n` low.
- R4: A read of addr 0 returns the synchronized pin levels and stores them as the new snapshot. This clears every change-mode request whose pin has not moved since.
- R5: Setting an enable bit while its pin already meets the mode condition makes the request visible on the next status read.
- R6: A high-to-low step of the shared line sets `irq` when both control bits are set. Another pin asserting while the line stays low does not set `irq` again after it has been acknowledged.
- R7: If either control bit (mask, bit 0; global enable, bit 1) is 0 when the line falls, `irq` stays 0.
- R8: A write to addr 5 with bit 0 = 1 clears `irq`. A write there with bit 0 = 0 leaves it unchanged.
- R9: Reset clears the enables, the mode, both control bits, `irq` and the snapshot (all zeros).
- R10: Changing the mode so that no enabled pin still qualifies releases `line_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPIN | Raw pin levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | NPIN | Write data |
| rdata | output | NPIN | Registered read data, valid the cycle after `rd_en` |
| line_n | output | 1 | Shared active-low request line |
| irq | output | 1 | Sticky system interrupt pending flag |

## Verification
Level mode is exercised with one pin low, then two pins low together, then both returning high. These cases show a fresh fall apart from an overlap that must stay silent, and they show the level release. Change mode is exercised with pins dropping against a snapshot of all ones, then a data read that moves the snapshot, then the pins rising back. These cases show that the comparison works in both directions and that a read clears the requests. The control bits are tried one at a time, to show that the gate needs both. A mid-run reset followed by change mode with the pins high shows that the snapshot was reset to zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_LEVELS = 3'd0;
  localparam logic [REG_AW-1:0] A_ENABLE = 3'd1;
  localparam logic [REG_AW-1:0] A_MODE   = 3'd2;
  localparam logic [REG_AW-1:0] A_CTRL   = 3'd3;
  localparam logic [REG_AW-1:0] A_STATUS = 3'd4;
  localparam logic [REG_AW-1:0] A_ACK    = 3'd5;

  typedef enum logic {
    MODE_LOW    = 1'b0,
    MODE_CHANGE = 1'b1
  } irq_mode_e;

  // Does one pin qualify for a request under the given mode?
  function automatic logic pin_qualifies(input logic armed, input irq_mode_e mode,
                                         input logic level, input logic snap);
    logic hit;
    hit = (mode == MODE_CHANGE) ? (level ^ snap) : ~level;
    return armed & hit;
  endfunction

  // Gate that lets a falling shared line become a system interrupt
  function automatic logic irq_gate(input logic gpio_mask, input logic global_en);
    return gpio_mask & global_en;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/gpio_irq_pins.sv
module gpio_irq_pins
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] level,
  input  logic [NPIN-1:0] armed,
  input  irq_mode_e       mode,
  input  logic            capture,
  output logic [NPIN-1:0] snap,
  output logic [NPIN-1:0] req,
  output logic            line_n
);
  logic [NPIN-1:0] pin_drive_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap <= '0;
    else if (capture) snap <= level;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign req[i]         = pin_qualifies(armed[i], mode, level[i], snap[i]);
    assign pin_drive_n[i] = ~req[i];
  end

  // Wired-OR of open-drain outputs: line is high only if nobody pulls it low
  assign line_n = &pin_drive_n;

  a_r4_read_moves_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (snap == $past(level)));

  a_r1_low_pin_pulls_line: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_LOW) && |(armed & ~level)) |-> !line_n);

  a_r3_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == '0) |-> line_n);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   level,
  input  logic [NPIN-1:0]   req,
  output logic [NPIN-1:0]   rdata,
  output logic [NPIN-1:0]   armed,
  output irq_mode_e         mode,
  output logic              gpio_mask,
  output logic              global_en,
  output logic              capture,
  output logic              ack
);
  logic [NPIN-1:0] rd_mux;

  assign capture = rd_en && (addr == A_LEVELS);
  assign ack     = wr_en && (addr == A_ACK) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= '0;
      mode      <= MODE_LOW;
      gpio_mask <= 1'b0;
      global_en <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_ENABLE: armed <= wdata;
        A_MODE:   mode  <= irq_mode_e'(wdata[0]);
        A_CTRL: begin
          gpio_mask <= wdata[0];
          global_en <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_LEVELS: rd_mux = level;
      A_ENABLE: rd_mux = armed;
      A_MODE:   rd_mux[0] = mode;
      A_CTRL:   rd_mux[1:0] = {global_en, gpio_mask};
      A_STATUS: rd_mux = req;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic gpio_mask,
  input  logic global_en,
  input  logic ack,
  output logic pending
);
  logic line_q;
  logic line_qq;
  logic fall_evt;
  logic gate_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b1;
      line_qq <= 1'b1;
    end else begin
      line_q  <= line_n;
      line_qq <= line_q;
    end
  end

  assign fall_evt  = line_qq & ~line_q;
  assign gate_open = irq_gate(gpio_mask, global_en);

  // A new event wins over a simultaneous acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else if (fall_evt && gate_open) pending <= 1'b1;
    else if (ack) pending <= 1'b0;
  end

  a_r6_set_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(fall_evt));

  a_r7_set_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(gate_open));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(fall_evt && gate_open)) |=> !pending);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   rdata,
  output logic              line_n,
  output logic              irq
);
  logic [NPIN-1:0] level;
  logic [NPIN-1:0] armed;
  logic [NPIN-1:0] snap;
  logic [NPIN-1:0] req;
  irq_mode_e       mode;
  logic            gpio_mask;
  logic            global_en;
  logic            capture;
  logic            ack;

  gpio_irq_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(level)
  );

  gpio_irq_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .level(level), .req(req), .rdata(rdata), .armed(armed),
    .mode(mode), .gpio_mask(gpio_mask), .global_en(global_en),
    .capture(capture), .ack(ack)
  );

  gpio_irq_pins #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst_n(rst_n), .level(level), .armed(armed), .mode(mode),
    .capture(capture), .snap(snap), .req(req), .line_n(line_n)
  );

  gpio_irq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .line_n(line_n), .gpio_mask(gpio_mask),
    .global_en(global_en), .ack(ack), .pending(irq)
  );

  a_r10_mode_release: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> line_n);
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         line_n;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.NPIN(N)) u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .line_n(line_n), .irq(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: compare each registered read result against the queued expectation
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: issue a read and push its expected value
  task automatic rd(input logic [2:0] a, input logic [N-1:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R9: reset state
    check_bit(irq, 1'b0, "R9 irq after reset");
    check_bit(line_n, 1'b1, "R9 line after reset");
    rd(3'd1, 8'h00, "R9 enable reset");
    rd(3'd2, 8'h00, "R9 mode reset");
    rd(3'd3, 8'h00, "R9 ctrl reset");

    // R3: unarmed pins low do nothing
    set_pins(8'h00);
    rd(3'd4, 8'h00, "R3 status unarmed");
    check_bit(line_n, 1'b1, "R3 line unarmed");
    set_pins(8'hFF);

    // R1/R6: level mode, one pin then overlap
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h05);
    set_pins(8'hFE);
    rd(3'd4, 8'h01, "R1 status pin0 low");
    check_bit(line_n, 1'b0, "R1 line low");
    check_bit(irq, 1'b1, "R6 irq on fall");
    set_pins(8'hFA);
    rd(3'd4, 8'h05, "R1 status two pins");
    wr(3'd5, 8'h01);
    settle();
    check_bit(irq, 1'b0, "R6 overlap raises nothing");
    set_pins(8'hFB);
    check_bit(irq, 1'b0, "R6 partial release raises nothing");
    check_bit(line_n, 1'b0, "R6 line still held");
    set_pins(8'hFF);
    rd(3'd4, 8'h00, "R1 status released");
    check_bit(line_n, 1'b1, "R1 line released");

    // R8: acknowledge bit semantics
    set_pins(8'hFA);
    check_bit(irq, 1'b1, "R6 new fall after release");
    wr(3'd5, 8'h00);
    settle();
    check_bit(irq, 1'b1, "R8 ack bit0=0 ignored");
    wr(3'd5, 8'h01);
    settle();
    check_bit(irq, 1'b0, "R8 ack clears");
    set_pins(8'hFF);

    // R3: disabled pin1 low
    set_pins(8'hFD);
    rd(3'd4, 8'h00, "R3 disabled pin1");
    check_bit(line_n, 1'b1, "R3 line disabled pin1");
    set_pins(8'hFF);

    // R7: gate needs both bits
    wr(3'd3, 8'h01);
    set_pins(8'hFE);
    check_bit(line_n, 1'b0, "R7 line low mask only");
    check_bit(irq, 1'b0, "R7 no irq without global enable");
    set_pins(8'hFF);
    wr(3'd3, 8'h02);
    set_pins(8'hFE);
    check_bit(irq, 1'b0, "R7 no irq without mask");
    set_pins(8'hFF);
    wr(3'd3, 8'h03);

    // R5: arming an already-low pin
    wr(3'd1, 8'h00);
    set_pins(8'hFB);
    wr(3'd1, 8'h04);
    rd(3'd4, 8'h04, "R5 immediate request");
    settle();
    check_bit(irq, 1'b1, "R5 irq after arming");
    wr(3'd1, 8'h00);
    rd(3'd4, 8'h00, "R3 disarm releases");
    settle();
    check_bit(line_n, 1'b1, "R3 line after disarm");
    wr(3'd5, 8'h01);
    set_pins(8'hFF);

    // R2/R4: change mode
    wr(3'd2, 8'h01);
    rd(3'd0, 8'hFF, "R4 read levels");
    wr(3'd1, 8'h0F);
    rd(3'd4, 8'h00, "R2 no change yet");
    set_pins(8'hF5);
    rd(3'd4, 8'h0A, "R2 falling change");
    check_bit(irq, 1'b1, "R6 irq in change mode");
    wr(3'd5, 8'h01);
    rd(3'd0, 8'hF5, "R4 read new levels");
    rd(3'd4, 8'h00, "R4 read clears requests");
    settle();
    check_bit(line_n, 1'b1, "R4 line released by read");
    set_pins(8'hFF);
    rd(3'd4, 8'h0A, "R2 rising change");

    // R10: mode change releases
    wr(3'd2, 8'h00);
    rd(3'd4, 8'h00, "R10 status after mode change");
    settle();
    check_bit(line_n, 1'b1, "R10 line after mode change");

    // R9: snapshot resets to zero
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check_bit(irq, 1'b0, "R9 irq after second reset");
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h01);
    rd(3'd4, 8'h01, "R9 snapshot zero after reset");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule